// File: doc/BRIEF.md
# Serial Converter Output Port Model

This block is a synthesizable, device-side model of the three-wire serial output of a 14-bit sampling converter. It is meant for a testbench or an emulator that needs the converter's digital behaviour at its pins without any analog modelling. A host lowers the conversion-start line, and the model raises its busy flag for a fixed number of system-clock cycles. When busy drops, the model captures the parallel result word presented on its input. The host then clocks the word out on the serial clock, and the model frames it exactly the way the converter does.

The serial frame is 16 bits long, sent most significant first. It starts with two zero bits, followed by the 14 result bits from the top bit down to bit 0. A separate enable output stands in for the three-state condition of the data pin. The model reproduces the framing corner cases of the converter:

- The first zero appears on the first rising serial-clock edge.
- Each later bit is advanced on a falling edge.
- The line goes undriven after the sixteenth falling edge.
- Any clocking after a complete frame restarts the word and leaves the line driven for good.

Both the serial clock and the conversion-start input are asynchronous to the system clock. Each passes through a synchronizer before its edges are detected.

Top module: `serial_adc_port`

## Requirements
- R1: After reset, `busy_o` is 0 and `sdata_oe_o` is 0.
- R2: A falling edge on `convst_i` starts a conversion: `busy_o` goes to 1 and stays 1 for exactly CONV_CYCLES system-clock cycles.
- R3: The output frame holds the value that `result_i` carries in the cycle where `busy_o` falls. Frame bit positions 0 and 1 (sent first) are 0, and positions 2 to 15 carry result bits 13 down to 0. A later change of `result_i` does not alter the frame.
- R4: While the line is undriven, a rising edge of `sclk_i` makes `sdata_oe_o` 1, and `sdata_o` then shows frame position 0, which is 0.
- R5: Each falling edge of `sclk_i` while driven advances the frame by one position, so after the k-th falling edge (k = 1..15) `sdata_o` shows frame position k. Rising edges after the first do not change `sdata_o`.
- R6: The 16th falling edge of a frame sets `sdata_oe_o` to 0, unless R7 applies.
- R7: A rising edge of `sclk_i` after a completed frame restarts output at frame position 0, and from then on `sdata_oe_o` stays 1. This holds after the 16th falling edge (output wraps to position 0) and while the clock is stopped.
- R8: Starting a conversion resets the shifter: `sdata_oe_o` becomes 0 and the restart condition of R7 is cleared.
- R9: A falling edge on `convst_i` while `busy_o` is 1 is ignored, so the busy period still lasts exactly CONV_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| result_i | input | DATA_W | Parallel conversion result, captured when busy falls |
| convst_i | input | 1 | Conversion start, asynchronous; falling edge starts a conversion |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sdata_o | output | 1 | Serial data bit (0 while not enabled) |
| sdata_oe_o | output | 1 | Data output enable; 0 represents the three-state condition |
| busy_o | output | 1 | Conversion in progress |

## Verification
The bench uses the default 14-bit data width and two synchronizer stages, with CONV_CYCLES reduced to 20. This short conversion time lets it run about twenty conversions: walking-one words, all-zero and all-one words, and alternating patterns. Every bit position of every frame is compared against the arithmetic expected frame, and the busy width is measured against the parameter. The small setting also leaves room for the corner cases: a second start request inside the busy window, result changes after capture, and an extended-clocking frame followed by a new conversion that must clear the restart condition.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    // Number of zero bits that precede the result in every frame.
    localparam int unsigned LEAD_ZEROS = 2;

    // Frame width for a given result width.
    function automatic int unsigned frame_width(input int unsigned data_w);
        return data_w + LEAD_ZEROS;
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d = st_q;
                st_d.chain = async_i;
            end
        end else begin : g_multi
            always_comb begin
                st_d = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int unsigned CONV_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic convst_sync_i,
    output logic start_o,
    output logic load_o,
    output logic busy_o
);

    localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(CONV_CYCLES - 1);

    typedef struct packed {
        logic             prev;
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;
    logic         fall_seen;

    always_comb begin
        st_d      = st_q;
        st_d.prev = convst_sync_i;
        fall_seen = st_q.prev && !convst_sync_i;
        start_o   = fall_seen && !st_q.busy;
        load_o    = st_q.busy && (st_q.cnt == '0);
        if (start_o) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_INIT;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.busy <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;

    // Independent width counter for the busy window check.
    logic [CNT_W:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (st_q.busy) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end else begin
            hi_cnt_q <= '0;
        end
    end

    // R2
    busy_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> (hi_cnt_q == (CNT_W+1)'(CONV_CYCLES)));

    // R9
    busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=> st_q.busy);

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import adc_port_pkg::*;
#(
    parameter int unsigned DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_sync_i,
    input  logic              start_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              sdata_o,
    output logic              oe_o
);

    localparam int unsigned FRAME_W = frame_width(DATA_W);
    localparam int unsigned POS_W   = $clog2(FRAME_W);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);

    typedef struct packed {
        logic               prev;
        logic [FRAME_W-1:0] frame;
        logic [POS_W-1:0]   pos;
        logic               oe;
        logic               sticky;
        logic               done;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sclk_sync_i;
        rise      = sclk_sync_i && !st_q.prev;
        fall      = !sclk_sync_i && st_q.prev;
        if (load_i) begin
            st_d.frame = {{LEAD_ZEROS{1'b0}}, data_i};
        end
        if (start_i) begin
            st_d.oe     = 1'b0;
            st_d.pos    = '0;
            st_d.sticky = 1'b0;
            st_d.done   = 1'b0;
        end else if (rise && !st_q.oe) begin
            st_d.oe     = 1'b1;
            st_d.pos    = '0;
            st_d.sticky = st_q.sticky || st_q.done;
            st_d.done   = 1'b0;
        end else if (fall && st_q.oe) begin
            if (st_q.pos == LAST_POS) begin
                st_d.pos = '0;
                if (!st_q.sticky) begin
                    st_d.oe   = 1'b0;
                    st_d.done = 1'b1;
                end
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_o    = st_q.oe;
    assign sdata_o = st_q.oe && st_q.frame[LAST_POS - st_q.pos];

    // R4
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> ($past(rise) && !sdata_o));

    // R6
    release_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.oe) |-> ($past(fall) || $past(start_i)));

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sticky && st_q.oe && !start_i) |=> st_q.oe);

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!st_q.oe && !st_q.sticky));

    // R3
    frame_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> $stable(st_q.frame));

endmodule

// File: rtl/serial_adc_port.sv
module serial_adc_port #(
    parameter int unsigned DATA_W      = 14,
    parameter int unsigned CONV_CYCLES = 10000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] result_i,
    input  logic              convst_i,
    input  logic              sclk_i,
    output logic              sdata_o,
    output logic              sdata_oe_o,
    output logic              busy_o
);

    logic convst_sync;
    logic sclk_sync;
    logic conv_start;
    logic conv_load;

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_convst_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (convst_i),
        .sync_o  (convst_sync)
    );

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sclk_i),
        .sync_o  (sclk_sync)
    );

    conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .convst_sync_i(convst_sync),
        .start_o      (conv_start),
        .load_o       (conv_load),
        .busy_o       (busy_o)
    );

    frame_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_sync_i (sclk_sync),
        .start_i     (conv_start),
        .load_i      (conv_load),
        .data_i      (result_i),
        .sdata_o     (sdata_o),
        .oe_o        (sdata_oe_o)
    );

endmodule

// File: tb/tb_serial_adc_port.sv
`timescale 1ns/1ps
module tb_serial_adc_port;

    localparam int unsigned DATA_W = 14;
    localparam int unsigned CONV   = 20;
    localparam int unsigned HALF   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] result_i = '0;
    logic              convst_i = 1'b1;
    logic              sclk_i = 1'b0;
    logic              sdata_o, sdata_oe_o, busy_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_adc_port #(.DATA_W(DATA_W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .result_i(result_i), .convst_i(convst_i),
        .sclk_i(sclk_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .busy_o(busy_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sclk_set(input logic v);
        sclk_i = v;
        repeat (HALF) @(negedge clk);
    endtask

    function automatic logic exp_bit(input logic [DATA_W+1:0] f, input int k);
        return f[DATA_W+1-k];
    endfunction

    task automatic run_conv(input logic [DATA_W-1:0] val, input bit glitch);
        int cnt = 0;
        int guard = 0;
        bit oe_checked = 1'b0;
        result_i = val;
        convst_i = 1'b1;
        repeat (HALF) @(negedge clk);
        convst_i = 1'b0;
        while (guard < 1000) begin
            @(negedge clk);
            guard++;
            if (busy_o) begin
                cnt++;
                if (!oe_checked) begin
                    // R8: shifter cleared once the conversion starts
                    chk("R8 oe after start", int'(sdata_oe_o), 0);
                    oe_checked = 1'b1;
                end
                if (glitch && cnt == 4) convst_i = 1'b1;
                if (glitch && cnt == 8) convst_i = 1'b0;
            end else if (cnt > 0) begin
                break;
            end
        end
        chk(glitch ? "R9 busy width with extra start" : "R2 busy width", cnt, int'(CONV));
        result_i = ~val;
    endtask

    task automatic read_frame(input logic [DATA_W-1:0] val, input bit extra);
        logic [DATA_W+1:0] f = {2'b00, val};
        chk("R4 idle before read", int'(sdata_oe_o), 0);
        sclk_set(1'b1);
        chk("R4 oe on first rise", int'(sdata_oe_o), 1);
        chk("R4 first bit", int'(sdata_o), 0);
        for (int k = 1; k < 16; k++) begin
            sclk_set(1'b0);
            chk(k >= 2 ? "R3 frame bit" : "R5 frame bit", int'(sdata_o), int'(exp_bit(f, k)));
            chk("R5 driven", int'(sdata_oe_o), 1);
            sclk_set(1'b1);
            chk("R5 stable on rise", int'(sdata_o), int'(exp_bit(f, k)));
        end
        sclk_set(1'b0);
        chk("R6 released after 16th fall", int'(sdata_oe_o), 0);
        if (extra) begin
            sclk_set(1'b1);
            chk("R7 restart oe", int'(sdata_oe_o), 1);
            chk("R7 restart bit", int'(sdata_o), 0);
            for (int k = 1; k < 16; k++) begin
                sclk_set(1'b0);
                chk("R7 restarted bit", int'(sdata_o), int'(exp_bit(f, k)));
                sclk_set(1'b1);
            end
            sclk_set(1'b0);
            chk("R7 still driven after 16th fall", int'(sdata_oe_o), 1);
            chk("R7 wrapped to first bit", int'(sdata_o), 0);
            repeat (20) @(negedge clk);
            chk("R7 driven with clock stopped", int'(sdata_oe_o), 1);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 busy after reset", int'(busy_o), 0);
        chk("R1 oe after reset", int'(sdata_oe_o), 0);

        run_conv(14'h2AAA, 1'b0);
        read_frame(14'h2AAA, 1'b1);
        run_conv(14'h1555, 1'b1);
        read_frame(14'h1555, 1'b0);
        run_conv(14'h0000, 1'b0);
        read_frame(14'h0000, 1'b0);
        run_conv(14'h3FFF, 1'b0);
        read_frame(14'h3FFF, 1'b1);
        run_conv(14'h2001, 1'b1);
        read_frame(14'h2001, 1'b0);
        for (int b = 0; b < DATA_W; b++) begin
            run_conv(14'(1 << b), 1'b0);
            read_frame(14'(1 << b), 1'b0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule